// File: doc/BRIEF.md
# Real-Time-Clock Shared Open-Drain Pin Selector

This block decides what a single open-drain pin of a real-time clock shows. The pin is shared by three functions: an interrupt line for the alarm and watchdog logic, a 512 Hz square wave used to measure the oscillator during manufacturing, and a plain level that software sets. The selection comes from control bits held in several different registers: stop, frequency-test, alarm-interrupt enable, watchdog steering and the watchdog register value. The block produces one output, `pull_low`. When it is 1 the pad sinks current. When it is 0 the pad floats, and an external pull-up makes the line high.

The frequency-test bit is stored inside the block because it has to clear when the supply fails. The rest of the control bits arrive as levels from their own registers. A strobe pulses once per half period of the 512 Hz test wave, which is 1024 pulses per second of oscillator time. The mode and the pull-low enable are both registered, so decode hazards never reach the pad.

Top module: `rtc_pin_selector`

## Requirements
- R1: While reset is held, and after it, until the first control input asks otherwise, `pull_low` is 0 (pin released) and `mode_o` is 0.
- R2: The interrupt function is selected (`mode_o` = 2) when `alarm_en` = 1, or when `wd_value` is nonzero and `wd_steer` = 0. In that mode `pull_low` equals `irq_req` one clock later.
- R3: The frequency-test function is selected (`mode_o` = 1) when the interrupt function is not selected, the stored test bit is 1 and `stop_bit` = 0.
- R4: In frequency-test mode the pin starts released and changes state once per `tick_half` pulse. It therefore completes 512 full periods per 1024 strobes, and `pull_low` follows each strobe two clocks later.
- R5: In every other case (`mode_o` = 0), `pull_low` is the inverse of `out_bit` one clock later, so a 0 level drives the pin low.
- R6: The interrupt function outranks the frequency test. When both sets of conditions hold, `mode_o` is 2.
- R7: `pwr_down` clears the stored test bit, and it wins over a write in the same cycle. From the second clock after the pulse the pin leaves frequency-test mode.
- R8: With `pwr_down` = 0, a cycle with `ft_wr_en` = 1 loads `ft_wr_val` into the stored test bit. The bit affects the mode from the second clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_bit | input | 1 | Oscillator stop control; 1 blocks the frequency test |
| ft_wr_en | input | 1 | Write strobe for the stored frequency-test bit |
| ft_wr_val | input | 1 | Value written into the frequency-test bit |
| pwr_down | input | 1 | Supply-fail indication; clears the frequency-test bit |
| out_bit | input | 1 | General-purpose output level |
| alarm_en | input | 1 | Alarm interrupt enable |
| wd_steer | input | 1 | Watchdog steering; 0 sends the watchdog to this pin |
| wd_value | input | WDOG_W | Watchdog register contents |
| irq_req | input | 1 | Interrupt request from alarm/watchdog logic |
| tick_half | input | 1 | One-cycle strobe per half period of the 512 Hz test wave |
| pull_low | output | 1 | 1 = pad sinks current, 0 = pad floats |
| mode_o | output | 2 | Selected function: 0 level, 1 frequency test, 2 interrupt |

## Verification
A wrong mode decode shows up on `mode_o` and on `pull_low` on the very next clock. The bench sweeps every mix of the control bits, with the watchdog both zero and nonzero and with the request both idle and active, so a wrong priority or a wrong condition surfaces there. A stuck or double-stepping test divider shows up as a wrong toggle count over one simulated second of strobes. A stored test bit that does not clear shows up two clocks after the power-down pulse as a lingering `mode_o` of 1.

// File: rtl/rtcpin_pkg.sv
package rtcpin_pkg;
  typedef enum logic [1:0] {
    PIN_LEVEL = 2'd0,
    PIN_FTEST = 2'd1,
    PIN_IRQ   = 2'd2
  } pin_mode_e;
endpackage

// File: rtl/rtcpin_rst_sync.sv
module rtcpin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/rtcpin_mode_dec.sv
module rtcpin_mode_dec
  import rtcpin_pkg::*;
#(
  parameter int WDOG_W = 8
) (
  input  logic              stop_bit,
  input  logic              ft_bit,
  input  logic              alarm_en,
  input  logic              wd_steer,
  input  logic [WDOG_W-1:0] wd_value,
  output pin_mode_e         mode
);
  logic wd_live;
  logic irq_sel;
  logic ft_sel;

  always_comb begin
    wd_live = |wd_value;
    irq_sel = alarm_en | (wd_live & ~wd_steer);
    ft_sel  = ~irq_sel & ft_bit & ~stop_bit;
    if (irq_sel)     mode = PIN_IRQ;
    else if (ft_sel) mode = PIN_FTEST;
    else             mode = PIN_LEVEL;
  end
endmodule

// File: rtl/rtcpin_ft_bit.sv
module rtcpin_ft_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic wr_en,
  input  logic wr_val,
  output logic ft_q
);
  logic ft_d;

  always_comb begin
    ft_d = ft_q;
    if (pwr_down)   ft_d = 1'b0;
    else if (wr_en) ft_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ft_q <= 1'b0;
    else        ft_q <= ft_d;
  end

  AST_PWRDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !ft_q); // R7
  AST_FT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pwr_down) |=> (ft_q == $past(wr_val))); // R8
endmodule

// File: rtl/rtcpin_sq_div.sv
module rtcpin_sq_div (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic sq_high
);
  logic sq_d;
  logic step_en;

  always_comb begin
    step_en = run & tick;
    sq_d    = sq_high;
    if (!run)        sq_d = 1'b1;
    else if (step_en) sq_d = ~sq_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_high <= 1'b1;
    else        sq_high <= sq_d;
  end

  AST_SQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (sq_high != $past(sq_high))); // R4
  AST_SQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sq_high)); // R4
  AST_SQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sq_high); // R4
endmodule

// File: rtl/rtc_pin_selector.sv
module rtc_pin_selector
  import rtcpin_pkg::*;
#(
  parameter int WDOG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_bit,
  input  logic              ft_wr_en,
  input  logic              ft_wr_val,
  input  logic              pwr_down,
  input  logic              out_bit,
  input  logic              alarm_en,
  input  logic              wd_steer,
  input  logic [WDOG_W-1:0] wd_value,
  input  logic              irq_req,
  input  logic              tick_half,
  output logic              pull_low,
  output logic [1:0]        mode_o
);
  logic      rst_s_n;
  logic      ft_q;
  logic      sq_high;
  pin_mode_e mode_d;
  pin_mode_e mode_q;
  logic      pull_d;
  logic      ft_run;

  rtcpin_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  rtcpin_ft_bit u_ft (
    .clk(clk), .rst_n(rst_s_n), .pwr_down(pwr_down),
    .wr_en(ft_wr_en), .wr_val(ft_wr_val), .ft_q(ft_q)
  );

  rtcpin_mode_dec #(.WDOG_W(WDOG_W)) u_dec (
    .stop_bit(stop_bit), .ft_bit(ft_q), .alarm_en(alarm_en),
    .wd_steer(wd_steer), .wd_value(wd_value), .mode(mode_d)
  );

  assign ft_run = (mode_d == PIN_FTEST);

  rtcpin_sq_div u_div (
    .clk(clk), .rst_n(rst_s_n), .run(ft_run), .tick(tick_half), .sq_high(sq_high)
  );

  always_comb begin
    unique case (mode_d)
      PIN_IRQ:   pull_d = irq_req;
      PIN_FTEST: pull_d = ~sq_high;
      default:   pull_d = ~out_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q   <= PIN_LEVEL;
      pull_low <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pull_low <= pull_d;
    end
  end

  assign mode_o = mode_q;

  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rst_s_n |-> (!pull_low && mode_q == PIN_LEVEL)); // R1
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_d == PIN_IRQ) |=> (pull_low == $past(irq_req))); // R2
  AST_ALARM_WINS: assert property (@(posedge clk) disable iff (!rst_s_n)
    alarm_en |=> (mode_q == PIN_IRQ)); // R6
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_d == PIN_LEVEL) |=> (pull_low == !$past(out_bit))); // R5
  AST_FT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == PIN_FTEST) |-> (ft_q || $past(ft_q))); // R3
endmodule

// File: tb/test_rtc_pin_selector.sv
module test_rtc_pin_selector;
  localparam int WDOG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_bit = 1'b0, ft_wr_en = 1'b0, ft_wr_val = 1'b0, pwr_down = 1'b0;
  logic out_bit = 1'b1, alarm_en = 1'b0, wd_steer = 1'b0, irq_req = 1'b0, tick_half = 1'b0;
  logic [WDOG_W-1:0] wd_value = '0;
  logic pull_low;
  logic [1:0] mode_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    int         due;
    logic [1:0] mode;
    logic       pull;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  rtc_pin_selector #(.WDOG_W(WDOG_W)) i_rtc_pin_selector (
    .clk(clk), .rst_n(rst_n), .stop_bit(stop_bit), .ft_wr_en(ft_wr_en),
    .ft_wr_val(ft_wr_val), .pwr_down(pwr_down), .out_bit(out_bit),
    .alarm_en(alarm_en), .wd_steer(wd_steer), .wd_value(wd_value),
    .irq_req(irq_req), .tick_half(tick_half), .pull_low(pull_low), .mode_o(mode_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops items due in this cycle and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(mode_o == e.mode, {e.tag, " mode"}, mode_o, e.mode);
      check(pull_low == e.pull, {e.tag, " pull"}, pull_low, e.pull);
    end
  end

  // reference model from requirements R2/R3/R5/R6 (no ticks pending)
  function automatic exp_t model(input bit st, input bit ft, input bit afe,
                                 input bit wds, input bit wdnz, input bit outb,
                                 input bit irq, input int due, input string tag);
    exp_t e;
    bit irqm, ftm;
    irqm = afe | (wdnz & ~wds);
    ftm  = ~irqm & ft & ~st;
    e.due = due;
    e.tag = tag;
    if (irqm)     begin e.mode = 2'd2; e.pull = irq;   end
    else if (ftm) begin e.mode = 2'd1; e.pull = 1'b0;  end
    else          begin e.mode = 2'd0; e.pull = ~outb; end
    return e;
  endfunction

  task automatic write_ft(input bit v);
    @(negedge clk);
    ft_wr_en = 1'b1; ft_wr_val = v;
    @(negedge clk);
    ft_wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int toggles = 0;
  bit count_on = 1'b0;
  logic last_pull = 1'b0;
  always @(negedge clk) begin
    if (count_on && pull_low != last_pull) toggles++;
    last_pull <= pull_low;
  end

  initial begin : driver
    string tg;
    repeat (3) @(negedge clk);
    check(pull_low == 1'b0, "R1 reset pull", pull_low, 0);
    check(mode_o == 2'd0, "R1 reset mode", mode_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pull_low == 1'b0, "R1 after reset pull", pull_low, 0);
    check(mode_o == 2'd0, "R1 after reset mode", mode_o, 0);

    // full sweep of the control bits: R2 R3 R5 R6 R8
    for (int k = 0; k < 64; k++) begin
      bit st, ft, afe, wds, wdnz, outb;
      {st, ft, afe, wds, wdnz, outb} = 6'(k);
      @(negedge clk);
      ft_wr_en = 1'b1; ft_wr_val = ft;
      @(negedge clk);
      ft_wr_en = 1'b0;
      stop_bit = st; alarm_en = afe; wd_steer = wds; out_bit = outb;
      wd_value = wdnz ? 8'h5A : 8'h00;
      irq_req = 1'b0;
      $sformat(tg, "R2/R3/R5/R6/R8 combo %0d irq0", k);
      sb.push_back(model(st, ft, afe, wds, wdnz, outb, 1'b0, cyc + 1, tg));
      @(negedge clk);
      irq_req = 1'b1;
      $sformat(tg, "R2/R3/R5/R6/R8 combo %0d irq1", k);
      sb.push_back(model(st, ft, afe, wds, wdnz, outb, 1'b1, cyc + 1, tg));
    end
    @(negedge clk);
    irq_req = 1'b0;
    repeat (3) @(negedge clk);

    // R4: one second of strobes in frequency-test mode
    stop_bit = 1'b0; alarm_en = 1'b0; wd_steer = 1'b1; wd_value = 8'h80; out_bit = 1'b1;
    write_ft(1'b1);
    repeat (3) @(negedge clk);
    check(mode_o == 2'd1, "R4 ftest mode", mode_o, 1);
    check(pull_low == 1'b0, "R4 ftest starts released", pull_low, 0);
    toggles = 0;
    count_on = 1'b1;
    for (int t = 0; t < 1024; t++) begin
      @(negedge clk); tick_half = 1'b1;
      @(negedge clk); tick_half = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    count_on = 1'b0;
    check(toggles == 1024, "R4 toggles per 1024 strobes", toggles, 1024);
    check(toggles / 2 == 512, "R4 periods per second", toggles / 2, 512);
    check(pull_low == 1'b0, "R4 ends released", pull_low, 0);

    // R4 latency: single strobe shows two clocks later
    @(negedge clk); tick_half = 1'b1;
    @(negedge clk); tick_half = 1'b0;
    check(pull_low == 1'b0, "R4 one clock after strobe", pull_low, 0);
    @(negedge clk);
    check(pull_low == 1'b1, "R4 two clocks after strobe", pull_low, 1);

    // R7: power-down beats a same-cycle write
    @(negedge clk);
    pwr_down = 1'b1; ft_wr_en = 1'b1; ft_wr_val = 1'b1;
    sb.push_back(model(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, cyc + 2, "R7 pwrdn clears ft"));
    @(negedge clk);
    pwr_down = 1'b0; ft_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check(mode_o == 2'd0, "R7 stays level", mode_o, 0);

    // R8: write restores the test function
    @(negedge clk);
    ft_wr_en = 1'b1; ft_wr_val = 1'b1;
    sb.push_back(model(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, cyc + 2, "R8 write ft"));
    @(negedge clk);
    ft_wr_en = 1'b0;
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule